// File: doc/BRIEF.md
# BAR decode validator

This block looks at the command word of a configuration-space function together with its seven base address registers (six ordinary windows plus one expansion ROM window). From these it works out, for each window, whether the window is currently decoded and at what aligned base. Window sizes and address-space types are static inputs. Each window's verdict and base are registered, so they appear one cycle after the inputs change.

A small state machine per window announces mapping changes as single-cycle pulses. When a window moves, it first withdraws the old base, then announces the new base. A lookup port takes an address and a space select and reports which decoded window claims that address.

The per-window event machine has three states. EV_STEADY is the idle state. EV_UNMAP drives the withdraw pulse. EV_MAP drives the announce pulse. The transitions are:
- STEADY→UNMAP when the published mapping differs from the last announced one and a base was announced.
- STEADY→MAP when the published mapping differs and nothing was announced.
- UNMAP→MAP when the window is currently valid.
- UNMAP→STEADY when the window is currently invalid.
- MAP→STEADY always.

Top module: `bar_map_unit`

## Requirements
- R1: While reset is held and just after it is released, every map_valid, map_evt, unmap_evt and hit_valid output is 0.
- R2: The command word selects which spaces decode. A window with reg_is_io=1 decodes only when cmd bit 0 is 1; any other window decodes only when cmd bit 1 is 1. The highest-index window is the ROM window: it is always treated as memory, and it also needs bit 0 of its BAR to be 1.
- R3: A window's base is its BAR value ANDed with the inverse of (size-1). map_valid and map_base reflect the inputs one clock after they are applied, and map_base reads 0 whenever map_valid is 0.
- R4: A window is never valid when any of these holds: its size is 0, its aligned base is 0, or its last address (base+size-1, wrapping in 32 bits) is not above its base.
- R5: An I/O window is invalid if its last address is 0x10000 or higher. A last address of exactly 0xFFFF is allowed.
- R6: A memory window is invalid if its last address is 0xFFFFFFFF.
- R7: When a window that was announced as mapped changes base or becomes invalid, unmap_evt pulses for exactly one cycle with the old base on evt_base. If the new mapping is valid, map_evt pulses in the very next cycle with the new base. Each pulse starts on the second clock edge after the input change at the earliest.
- R8: A window going from unmapped to mapped produces only a map_evt pulse and no unmap_evt.
- R9: One clock after lk_addr and lk_is_io are applied, hit_valid is 1 if a valid window matches. A window matches when its space equals lk_is_io and (lk_addr AND NOT(size-1)) equals its base. hit_idx then gives that window's index.
- R10: If several windows claim the lookup address, hit_idx is the lowest matching index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 16 | Command word; bit 0 enables I/O decode, bit 1 enables memory decode |
| bar_val | input | NREG x AW | Programmed BAR value per window (ROM is the highest index) |
| reg_size | input | NREG x AW | Window size in bytes, a power of two or 0 |
| reg_is_io | input | NREG | 1 marks an I/O window (ignored for the ROM window) |
| lk_addr | input | AW | Lookup address |
| lk_is_io | input | 1 | Lookup space: 1 = I/O, 0 = memory |
| map_valid | output | NREG | Window currently decoded |
| map_base | output | NREG x AW | Current aligned base, 0 when not decoded |
| map_evt | output | NREG | One-cycle pulse announcing a new base |
| unmap_evt | output | NREG | One-cycle pulse withdrawing an old base |
| evt_base | output | NREG x AW | Base that goes with the current pulse |
| hit_valid | output | 1 | A window claims the lookup address |
| hit_idx | output | IW | Index of the claiming window |

## Verification
On every cycle the assertions check the following:
- map_base is zero for undecoded windows, and nonzero and aligned for decoded ones.
- A decoded window had its command enable bit set in the previous cycle.
- A decoded I/O window sits below the 64K limit.
- Neither event pulse lasts more than a cycle, and the two pulses never coincide.
- A hit only occurs while some window is decoded.

Only the bench scenarios can show the rest: that the exact boundary addresses (last address 0xFFFF versus 0x10000, and 0xFFFFFFFF) are judged correctly, and that the ROM enable bit gates the ROM window. They also show that a move produces the old-base withdrawal directly before the new-base announcement, and that overlapping windows resolve to the lowest index.

// File: rtl/barmap_pkg.sv
package barmap_pkg;

    typedef enum logic [1:0] {
        EV_STEADY = 2'd0,
        EV_UNMAP  = 2'd1,
        EV_MAP    = 2'd2
    } ev_state_e;

    localparam int CMD_IO_BIT  = 0;
    localparam int CMD_MEM_BIT = 1;

endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval #(
    parameter int           AW       = 32,
    parameter logic [AW-1:0] IO_LIMIT = 'h10000,
    parameter bit           IS_ROM   = 1'b0
) (
    input  logic          io_en,
    input  logic          mem_en,
    input  logic [AW-1:0] bar,
    input  logic [AW-1:0] size,
    input  logic          is_io,
    output logic          ok,
    output logic [AW-1:0] base
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] mask;
    logic [AW-1:0] base_c;
    logic [AW-1:0] last;
    logic          io_space;
    logic          enabled;
    logic          range_ok;

    always_comb begin
        mask     = ~(size - ONE);
        base_c   = bar & mask;
        last     = base_c + size - ONE;
        io_space = is_io && !IS_ROM;
        enabled  = io_space ? io_en : mem_en;
        if (IS_ROM && !bar[0]) begin
            enabled = 1'b0;
        end
        range_ok = io_space ? (last < IO_LIMIT) : (last != {AW{1'b1}});
        ok       = enabled && (size != '0) && (base_c != '0)
                   && (last > base_c) && range_ok;
        base     = ok ? base_c : '0;
    end
endmodule

// File: rtl/bar_event_fsm.sv
module bar_event_fsm
    import barmap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cur_ok,
    input  logic [AW-1:0] cur_base,
    output logic          map_p,
    output logic          unmap_p,
    output logic [AW-1:0] ev_base
);
    ev_state_e     st;
    ev_state_e     nxt;
    logic          ann_ok;
    logic [AW-1:0] ann_base;
    logic          differ;

    always_comb begin
        differ = (cur_ok != ann_ok) || (cur_ok && (cur_base != ann_base));
        unique case (st)
            EV_STEADY: nxt = !differ ? EV_STEADY : (ann_ok ? EV_UNMAP : EV_MAP);
            EV_UNMAP:  nxt = cur_ok ? EV_MAP : EV_STEADY;
            EV_MAP:    nxt = EV_STEADY;
            default:   nxt = EV_STEADY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= EV_STEADY;
        end else begin
            st <= nxt;
        end
    end

    // announced mapping and the base carried with each pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ann_ok   <= 1'b0;
            ann_base <= '0;
            ev_base  <= '0;
        end else if (nxt == EV_UNMAP) begin
            ev_base  <= ann_base;
            ann_ok   <= 1'b0;
            ann_base <= '0;
        end else if (nxt == EV_MAP) begin
            ev_base  <= cur_base;
            ann_ok   <= 1'b1;
            ann_base <= cur_base;
        end
    end

    assign map_p   = (st == EV_MAP);
    assign unmap_p = (st == EV_UNMAP);
endmodule

// File: rtl/bar_hit_sel.sv
module bar_hit_sel #(
    parameter int NREG = 7,
    parameter int AW   = 32,
    parameter int IW   = 3
) (
    input  logic [NREG-1:0]         ok,
    input  logic [NREG-1:0][AW-1:0] base,
    input  logic [NREG-1:0][AW-1:0] size,
    input  logic [NREG-1:0]         io_sp,
    input  logic [AW-1:0]           addr,
    input  logic                    want_io,
    output logic                    hit,
    output logic [IW-1:0]           idx
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (ok[i] && (io_sp[i] == want_io)
                && ((addr & ~(size[i] - ONE)) == base[i])) begin
                hit = 1'b1;
                idx = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/bar_map_unit.sv
module bar_map_unit
    import barmap_pkg::*;
#(
    parameter int            NREG     = 7,
    parameter int            AW       = 32,
    parameter logic [AW-1:0] IO_LIMIT = 'h10000,
    localparam int           IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             cmd,
    input  logic [NREG-1:0][AW-1:0] bar_val,
    input  logic [NREG-1:0][AW-1:0] reg_size,
    input  logic [NREG-1:0]         reg_is_io,
    input  logic [AW-1:0]           lk_addr,
    input  logic                    lk_is_io,
    output logic [NREG-1:0]         map_valid,
    output logic [NREG-1:0][AW-1:0] map_base,
    output logic [NREG-1:0]         map_evt,
    output logic [NREG-1:0]         unmap_evt,
    output logic [NREG-1:0][AW-1:0] evt_base,
    output logic                    hit_valid,
    output logic [IW-1:0]           hit_idx
);
    localparam int ROM_IDX = NREG - 1;

    logic [NREG-1:0]         nx_ok;
    logic [NREG-1:0][AW-1:0] nx_base;
    logic [NREG-1:0]         io_sp;
    logic                    hit_c;
    logic [IW-1:0]           idx_c;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign io_sp[g] = reg_is_io[g] && (g != ROM_IDX);

        bar_region_eval #(
            .AW       (AW),
            .IO_LIMIT (IO_LIMIT),
            .IS_ROM   (g == ROM_IDX)
        ) eval_i (
            .io_en  (cmd[CMD_IO_BIT]),
            .mem_en (cmd[CMD_MEM_BIT]),
            .bar    (bar_val[g]),
            .size   (reg_size[g]),
            .is_io  (reg_is_io[g]),
            .ok     (nx_ok[g]),
            .base   (nx_base[g])
        );

        bar_event_fsm #(.AW(AW)) fsm_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_ok   (map_valid[g]),
            .cur_base (map_base[g]),
            .map_p    (map_evt[g]),
            .unmap_p  (unmap_evt[g]),
            .ev_base  (evt_base[g])
        );
    end

    bar_hit_sel #(.NREG(NREG), .AW(AW), .IW(IW)) hit_i (
        .ok      (map_valid),
        .base    (map_base),
        .size    (reg_size),
        .io_sp   (io_sp),
        .addr    (lk_addr),
        .want_io (lk_is_io),
        .hit     (hit_c),
        .idx     (idx_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_valid <= '0;
            map_base  <= '0;
            hit_valid <= 1'b0;
            hit_idx   <= '0;
        end else begin
            map_valid <= nx_ok;
            map_base  <= nx_base;
            hit_valid <= hit_c;
            hit_idx   <= idx_c;
        end
    end
endmodule

// File: rtl/bar_map_unit_chk.sv
module bar_map_unit_chk #(
    parameter int            NREG     = 7,
    parameter int            AW       = 32,
    parameter logic [AW-1:0] IO_LIMIT = 'h10000,
    parameter int            IW       = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [15:0]             cmd,
    input logic [NREG-1:0][AW-1:0] reg_size,
    input logic [NREG-1:0]         reg_is_io,
    input logic [NREG-1:0]         map_valid,
    input logic [NREG-1:0][AW-1:0] map_base,
    input logic [NREG-1:0]         map_evt,
    input logic [NREG-1:0]         unmap_evt,
    input logic                    hit_valid,
    input logic [IW-1:0]           hit_idx
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        a_r3_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            !map_valid[g] |-> (map_base[g] == '0));

        a_r4_nonzero_base: assert property (@(posedge clk) disable iff (!rst_n)
            map_valid[g] |-> (map_base[g] != '0));

        a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            map_valid[g] |-> ((map_base[g] & ($past(reg_size[g]) - ONE)) == '0));

        a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
            map_valid[g] |-> (($past(reg_is_io[g]) && (g != NREG - 1))
                              ? $past(cmd[0]) : $past(cmd[1])));

        a_r5_io_limit: assert property (@(posedge clk) disable iff (!rst_n)
            (map_valid[g] && $past(reg_is_io[g]) && (g != NREG - 1))
            |-> (map_base[g] < IO_LIMIT));

        a_r7_unmap_single: assert property (@(posedge clk) disable iff (!rst_n)
            unmap_evt[g] |=> !unmap_evt[g]);

        a_r7_map_single: assert property (@(posedge clk) disable iff (!rst_n)
            map_evt[g] |=> !map_evt[g]);

        a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            unmap_evt[g] |-> !map_evt[g]);
    end

    a_r9_hit_needs_map: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> ($past(map_valid) != '0));

    a_r9_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_idx < IW'(NREG)));
endmodule

bind bar_map_unit bar_map_unit_chk #(
    .NREG     (NREG),
    .AW       (AW),
    .IO_LIMIT (IO_LIMIT),
    .IW       (IW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .reg_size  (reg_size),
    .reg_is_io (reg_is_io),
    .map_valid (map_valid),
    .map_base  (map_base),
    .map_evt   (map_evt),
    .unmap_evt (unmap_evt),
    .hit_valid (hit_valid),
    .hit_idx   (hit_idx)
);

// File: tb/bar_map_unit_tb_top.sv
module bar_map_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 7;
    localparam int AW   = 32;
    localparam int IW   = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [15:0]             cmd = '0;
    logic [NREG-1:0][AW-1:0] bar_val = '0;
    logic [NREG-1:0][AW-1:0] reg_size = '0;
    logic [NREG-1:0]         reg_is_io = '0;
    logic [AW-1:0]           lk_addr = '0;
    logic                    lk_is_io = 1'b0;
    logic [NREG-1:0]         map_valid;
    logic [NREG-1:0][AW-1:0] map_base;
    logic [NREG-1:0]         map_evt;
    logic [NREG-1:0]         unmap_evt;
    logic [NREG-1:0][AW-1:0] evt_base;
    logic                    hit_valid;
    logic [IW-1:0]           hit_idx;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    bar_map_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bar_val(bar_val),
        .reg_size(reg_size), .reg_is_io(reg_is_io), .lk_addr(lk_addr),
        .lk_is_io(lk_is_io), .map_valid(map_valid), .map_base(map_base),
        .map_evt(map_evt), .unmap_evt(unmap_evt), .evt_base(evt_base),
        .hit_valid(hit_valid), .hit_idx(hit_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        n_checks++;
        if (!good) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit eff_io(input int i);
        return reg_is_io[i] && (i != NREG - 1);
    endfunction

    function automatic bit ref_ok(input int i);
        logic [31:0] b, l, s;
        bit en;
        s  = reg_size[i];
        b  = bar_val[i] & ~(s - 32'd1);
        l  = b + s - 32'd1;
        en = eff_io(i) ? cmd[0] : cmd[1];
        if (i == NREG - 1 && !bar_val[i][0]) en = 1'b0;
        if (!en || s == 0 || b == 0 || l <= b) return 1'b0;
        if (eff_io(i)) return l < 32'h10000;
        return l != 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] ref_base(input int i);
        return ref_ok(i) ? (bar_val[i] & ~(reg_size[i] - 32'd1)) : 32'd0;
    endfunction

    function automatic int ref_hit(input logic [31:0] a, input bit sp);
        for (int i = 0; i < NREG; i++) begin
            if (ref_ok(i) && eff_io(i) == sp
                && ((a & ~(reg_size[i] - 32'd1)) == ref_base(i)))
                return i;
        end
        return -1;
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < NREG; i++) begin
            chk(map_valid[i] == ref_ok(i), req, map_valid[i], ref_ok(i));
            chk(map_base[i] == ref_base(i), req, map_base[i], ref_base(i));
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] a, input bit sp, input string req);
        int e;
        lk_addr  = a;
        lk_is_io = sp;
        e = ref_hit(a, sp);
        @(negedge clk);
        chk(hit_valid == (e >= 0), req, hit_valid, e >= 0);
        if (e >= 0) chk(hit_idx == e[IW-1:0], req, hit_idx, e);
    endtask

    task automatic watch(input int k, output int nu, output int nm, output int ua,
                         output int ma, output logic [31:0] ub, output logic [31:0] mb);
        nu = 0; nm = 0; ua = -1; ma = -1; ub = '0; mb = '0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (unmap_evt[k]) begin nu++; ua = c; ub = evt_base[k]; end
            if (map_evt[k])   begin nm++; ma = c; mb = evt_base[k]; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int nu, nm, ua, ma;
        logic [31:0] ub, mb;
        void'($urandom(32'd4711));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(map_valid == '0, "R1", map_valid, 0);
        chk(map_evt == '0 && unmap_evt == '0, "R1", {map_evt, unmap_evt}, 0);
        chk(hit_valid == 1'b0, "R1", hit_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(map_valid == '0, "R1", map_valid, 0);

        // directed validity corners
        cmd = 16'h0003;
        reg_is_io = 7'b0000011;
        bar_val[0] = 32'h0000_FF01; reg_size[0] = 32'h100;
        bar_val[1] = 32'h0001_0000; reg_size[1] = 32'h100;
        bar_val[2] = 32'hFFFF_F000; reg_size[2] = 32'h1000;
        bar_val[3] = 32'hFFFF_E000; reg_size[3] = 32'h1000;
        bar_val[4] = 32'h0000_00F0; reg_size[4] = 32'h100;
        bar_val[5] = 32'h0000_1000; reg_size[5] = 32'h0;
        bar_val[6] = 32'h000C_0000; reg_size[6] = 32'h1_0000;
        @(negedge clk);
        chk(map_valid[0] && map_base[0] == 32'hFF00, "R5", map_base[0], 32'hFF00);
        chk(!map_valid[1], "R5", map_valid[1], 0);
        chk(!map_valid[2], "R6", map_valid[2], 0);
        chk(map_valid[3] && map_base[3] == 32'hFFFF_E000, "R6", map_base[3], 32'hFFFF_E000);
        chk(!map_valid[4] && map_base[4] == 0, "R4", map_base[4], 0);
        chk(!map_valid[5], "R4", map_valid[5], 0);
        chk(!map_valid[6], "R2", map_valid[6], 0);
        check_all("R3");
        bar_val[6] = 32'h000C_0001;
        bar_val[5] = 32'h0000_2000; reg_size[5] = 32'h1;
        @(negedge clk);
        chk(map_valid[6] && map_base[6] == 32'h000C_0000, "R2", map_base[6], 32'hC0000);
        chk(!map_valid[5], "R4", map_valid[5], 0);
        cmd = 16'h0001;
        @(negedge clk);
        chk(map_valid[0] && !map_valid[3] && !map_valid[6], "R2", map_valid, 7'b0000001);
        cmd = 16'h0002;
        @(negedge clk);
        chk(!map_valid[0] && map_valid[3], "R2", map_valid, 7'b1001000);
        cmd = 16'h0003;
        settle();

        // R7: move a mapped window
        bar_val[3] = 32'h4000_0000;
        watch(3, nu, nm, ua, ma, ub, mb);
        chk(nu == 1 && ub == 32'hFFFF_E000, "R7", ub, 32'hFFFF_E000);
        chk(nm == 1 && mb == 32'h4000_0000, "R7", mb, 32'h4000_0000);
        chk(ma == ua + 1 && ua >= 1, "R7", ma, ua + 1);
        // R8: unmap only
        bar_val[3] = 32'h0;
        watch(3, nu, nm, ua, ma, ub, mb);
        chk(nu == 1 && nm == 0 && ub == 32'h4000_0000, "R8", {nu, nm}, 64'h1_0000_0000);
        // R8: map only
        bar_val[3] = 32'h5000_0000;
        watch(3, nu, nm, ua, ma, ub, mb);
        chk(nu == 0 && nm == 1 && mb == 32'h5000_0000, "R8", {nu, nm}, 1);

        // R9 / R10: lookup
        bar_val[1] = 32'h5000_0000; reg_size[1] = 32'h1000; reg_is_io[1] = 1'b0;
        settle();
        lookup(32'h5000_0010, 1'b0, "R10");
        chk(hit_idx == 3'd1, "R10", hit_idx, 1);
        lookup(32'h5000_0010, 1'b1, "R9");
        lookup(32'h0000_FF20, 1'b1, "R9");
        lookup(32'h0000_FF20, 1'b0, "R9");
        lookup(32'h000C_8000, 1'b0, "R9");

        // random configurations
        for (int it = 0; it < 300; it++) begin
            cmd = 16'($urandom % 4);
            for (int i = 0; i < NREG; i++) begin
                reg_is_io[i] = $urandom % 2;
                if ($urandom % 8 == 0) reg_size[i] = 0;
                else if (reg_is_io[i]) reg_size[i] = 32'd1 << ($urandom % 9);
                else reg_size[i] = 32'd1 << (4 + $urandom % 20);
                if ($urandom % 10 == 0) bar_val[i] = 0;
                else if (reg_is_io[i] && i != NREG - 1) bar_val[i] = $urandom % 32'h14000;
                else bar_val[i] = $urandom;
            end
            settle();
            check_all("R3");
            for (int q = 0; q < 4; q++) begin
                int r;
                r = $urandom % NREG;
                if ($urandom % 4 == 0)
                    lookup($urandom, $urandom % 2, "R9");
                else
                    lookup((bar_val[r] & ~(reg_size[r] - 1)) + ($urandom % (reg_size[r] + 1)),
                           eff_io(r), "R9");
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule